// File: doc/BRIEF.md
# Pin-Bank External Interrupt Controller

This block watches one bank of up to eight general-purpose input pins and turns activity on them into a single interrupt request. Each pin first passes through a two-stage synchronizer. It then goes through an optional digital deglitch filter that counts clock cycles, and finally through a trigger detector. The trigger detector is programmed per pin for a low level, a high level, a falling edge, a rising edge or either edge. A detected event sets the pin's pending bit. The interrupt output is raised while any pending pin is unmasked.

Software reaches the block through a word-wide register port. The port holds five registers: the trigger control word, two filter words, the mask and the pending bits. Writes take effect on the next clock edge. Reads are combinational from the addressed register.

The filter in each pin is a two-state machine. In state FLT_STABLE the filtered level matches the synchronized input. Transition STABLE->COUNT is taken when the input first differs, unless the width is 1. Transition COUNT->STABLE is taken in two cases. It is taken when the input returns to the held level, which abandons the count. It is also taken when the count reaches the programmed width, in which case the new level is committed. When the filter is bypassed, the machine is held in FLT_STABLE and the level follows the input each cycle.

Top module: `pinbank_irq_ctrl`

## Requirements
- R1: The trigger control word sits at register address 0. Pin n is configured by bits [4n+3:4n]. Every field resets to 15.
- R2: Trigger codes select the event type: 0 = level low, 1 = level high, 2 = falling edge, 3 = rising edge, 4 = both edges.
- R3: Trigger codes 5 through 15 never set a pending bit, whatever the pin does.
- R4: Each pin has a filter byte in which bit 7 enables the filter, bit 6 selects digital mode (1) or analog mode (0), and bits 5:0 give the width. Pins 0-3 are held in the word at address 1 and pins 4-7 in the word at address 2. Pin k of a word occupies bits [8k+7:8k]. Every byte reads back as written.
- R5: With the filter disabled, in analog mode, or in digital mode with width 0, the synchronized pin level reaches the detector one cycle later. A single-cycle pulse is therefore still detected.
- R6: In digital mode with width W>0, the filtered level changes only after the synchronized input has differed from it for W consecutive cycles. Any return to the held level restarts the count.
- R7: An edge trigger sets the pending bit once per filtered transition. A level trigger keeps setting it on every cycle that the level is present.
- R8: The pending register sits at address 4. Writing 1 to a bit clears it and writing 0 leaves it unchanged. A set bit holds until it is cleared.
- R9: When an event and a clear of the same pin fall in one cycle, the event wins and the bit stays set.
- R10: The mask register sits at address 3 and resets to all ones (masked). irq_o is the OR over all pins of pending AND NOT mask.
- R11: After reset, the pending bits and the filter bytes are 0 and irq_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | NUM_PINS | Raw pin levels, asynchronous to clk_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 3 | Register word address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check several properties on every cycle and for every pin. Disabled trigger codes never produce an event. An event always leaves the pending bit set, even against a clear. A clear without an event drops the bit, and a pending bit never drops on its own. A bypassed filter copies its input one cycle later, and a digital filter of width two or more holds its level on the first differing cycle. A fully masked or empty pending register keeps irq_o low. Only the directed scenarios can show the rest: that each trigger code fires on the right transition of a real pin waveform, that pulses just shorter or just as long as the filter width are rejected or passed, that a glitch restarts the count, and that the register fields sit at the stated bit positions.

// File: rtl/pinbank_irq_pkg.sv
package pinbank_irq_pkg;

    localparam int FLT_WIDTH_BITS = 6;

    // register word addresses
    localparam logic [2:0] ADR_TRIG   = 3'd0;
    localparam logic [2:0] ADR_FLT_LO = 3'd1;
    localparam logic [2:0] ADR_FLT_HI = 3'd2;
    localparam logic [2:0] ADR_MASK   = 3'd3;
    localparam logic [2:0] ADR_PEND   = 3'd4;

    // trigger codes
    localparam logic [3:0] TRG_LVL_LO = 4'd0;
    localparam logic [3:0] TRG_LVL_HI = 4'd1;
    localparam logic [3:0] TRG_FALL   = 4'd2;
    localparam logic [3:0] TRG_RISE   = 4'd3;
    localparam logic [3:0] TRG_BOTH   = 4'd4;

    typedef struct packed {
        logic                      en;
        logic                      digital;
        logic [FLT_WIDTH_BITS-1:0] width;
    } flt_cfg_t;

    typedef enum logic {
        FLT_STABLE,
        FLT_COUNT
    } flt_state_e;

endpackage

// File: rtl/pinbank_sync.sv
module pinbank_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/pinbank_deglitch.sv
module pinbank_deglitch
    import pinbank_irq_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  flt_cfg_t cfg_i,
    input  logic     d_i,
    output logic     q_o
);
    localparam int CW = FLT_WIDTH_BITS;

    flt_state_e    state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;
    logic          lvl_q, lvl_d;
    logic          bypass;
    logic [CW:0]   cnt_nxt;

    assign bypass  = !cfg_i.en || !cfg_i.digital || (cfg_i.width == '0);
    assign cnt_nxt = {1'b0, cnt_q} + 1'b1;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= FLT_STABLE;
            cnt_q   <= '0;
            lvl_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            lvl_q   <= lvl_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        lvl_d   = lvl_q;
        if (bypass) begin
            state_d = FLT_STABLE;
            cnt_d   = '0;
            lvl_d   = d_i;
        end else begin
            unique case (state_q)
                FLT_STABLE: begin
                    if (d_i != lvl_q) begin
                        if (cfg_i.width == CW'(1)) begin
                            lvl_d = d_i;
                        end else begin
                            state_d = FLT_COUNT;
                            cnt_d   = CW'(1);
                        end
                    end
                end
                FLT_COUNT: begin
                    if (d_i == lvl_q) begin
                        state_d = FLT_STABLE;
                        cnt_d   = '0;
                    end else if (cnt_nxt >= {1'b0, cfg_i.width}) begin
                        state_d = FLT_STABLE;
                        cnt_d   = '0;
                        lvl_d   = d_i;
                    end else begin
                        cnt_d = cnt_nxt[CW-1:0];
                    end
                end
                default: state_d = FLT_STABLE;
            endcase
        end
    end

    assign q_o = lvl_q;
endmodule

// File: rtl/pinbank_trigger.sv
module pinbank_trigger
    import pinbank_irq_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lvl_i,
    input  logic [3:0] code_i,
    output logic       evt_o
);
    logic prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) prev_q <= 1'b0;
        else         prev_q <= lvl_i;
    end

    always_comb begin
        case (code_i)
            TRG_LVL_LO: evt_o = !lvl_i;
            TRG_LVL_HI: evt_o = lvl_i;
            TRG_FALL:   evt_o = prev_q && !lvl_i;
            TRG_RISE:   evt_o = !prev_q && lvl_i;
            TRG_BOTH:   evt_o = prev_q ^ lvl_i;
            default:    evt_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/pinbank_irq_ctrl.sv
module pinbank_irq_ctrl
    import pinbank_irq_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic                reg_wr_i,
    input  logic [2:0]          reg_addr_i,
    input  logic [31:0]         reg_wdata_i,
    output logic [31:0]         reg_rdata_o,
    output logic                irq_o
);
    localparam int TRIG_BITS     = 4 * NUM_PINS;
    localparam int PINS_PER_WORD = 4;

    logic [TRIG_BITS-1:0] trig_q;
    flt_cfg_t             flt_q [NUM_PINS];
    logic [NUM_PINS-1:0]  mask_q, pend_q, clr, evt, sync_out, filt_out;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            trig_q <= {TRIG_BITS{1'b1}};
            mask_q <= '1;
            pend_q <= '0;
        end else begin
            if (reg_wr_i && reg_addr_i == ADR_TRIG) trig_q <= reg_wdata_i[TRIG_BITS-1:0];
            if (reg_wr_i && reg_addr_i == ADR_MASK) mask_q <= reg_wdata_i[NUM_PINS-1:0];
            pend_q <= (pend_q & ~clr) | evt;
        end
    end

    assign clr = (reg_wr_i && reg_addr_i == ADR_PEND) ? reg_wdata_i[NUM_PINS-1:0] : '0;

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        localparam logic [2:0] FLT_ADR = ADR_FLT_LO + 3'(p / PINS_PER_WORD);
        localparam int         BYTE_LO = 8 * (p % PINS_PER_WORD);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni)                                 flt_q[p] <= '0;
            else if (reg_wr_i && reg_addr_i == FLT_ADR)  flt_q[p] <= reg_wdata_i[BYTE_LO +: 8];
        end

        pinbank_sync #(.STAGES(SYNC_STAGES)) sync_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .d_i   (pin_i[p]),
            .q_o   (sync_out[p])
        );

        pinbank_deglitch flt_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .cfg_i (flt_q[p]),
            .d_i   (sync_out[p]),
            .q_o   (filt_out[p])
        );

        pinbank_trigger trg_i (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .lvl_i (filt_out[p]),
            .code_i(trig_q[4*p +: 4]),
            .evt_o (evt[p])
        );
    end

    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADR_TRIG: reg_rdata_o[TRIG_BITS-1:0] = trig_q;
            ADR_FLT_LO, ADR_FLT_HI: begin
                for (int p = 0; p < NUM_PINS; p++) begin
                    if (3'(p / PINS_PER_WORD) == reg_addr_i - ADR_FLT_LO)
                        reg_rdata_o[8*(p % PINS_PER_WORD) +: 8] = flt_q[p];
                end
            end
            ADR_MASK: reg_rdata_o[NUM_PINS-1:0] = mask_q;
            ADR_PEND: reg_rdata_o[NUM_PINS-1:0] = pend_q;
            default:  reg_rdata_o = '0;
        endcase
    end

    assign irq_o = |(pend_q & ~mask_q);
endmodule

// File: rtl/pinbank_irq_chk.sv
module pinbank_irq_chk
    import pinbank_irq_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                  clk_i,
    input logic                  rst_ni,
    input logic                  irq_o,
    input logic [NUM_PINS-1:0]   mask_q,
    input logic [NUM_PINS-1:0]   pend_q,
    input logic [NUM_PINS-1:0]   clr,
    input logic [NUM_PINS-1:0]   evt,
    input logic [4*NUM_PINS-1:0] trig_q,
    input logic [NUM_PINS-1:0]   sync_out,
    input logic [NUM_PINS-1:0]   filt_out,
    input flt_cfg_t              flt_q [NUM_PINS]
);
    assert_masked_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (&mask_q) |-> !irq_o);
    assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_q == '0) |-> !irq_o);

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_chk
        assert_bad_code_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (trig_q[4*i +: 4] > 4'd4) |-> !evt[i]);
        assert_event_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
            evt[i] |=> pend_q[i]);
        assert_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (clr[i] && !evt[i]) |=> !pend_q[i]);
        assert_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (pend_q[i] && !clr[i]) |=> pend_q[i]);
        assert_bypass_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (!flt_q[i].en || !flt_q[i].digital || flt_q[i].width == '0)
            |=> filt_out[i] == $past(sync_out[i]));
        assert_first_diff_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (flt_q[i].en && flt_q[i].digital && flt_q[i].width > 6'd1 &&
             sync_out[i] != filt_out[i] && $past(sync_out[i] == filt_out[i]))
            |=> $stable(filt_out[i]));
    end
endmodule

bind pinbank_irq_ctrl pinbank_irq_chk #(.NUM_PINS(NUM_PINS)) chk_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .irq_o   (irq_o),
    .mask_q  (mask_q),
    .pend_q  (pend_q),
    .clr     (clr),
    .evt     (evt),
    .trig_q  (trig_q),
    .sync_out(sync_out),
    .filt_out(filt_out),
    .flt_q   (flt_q)
);

// File: tb/pinbank_irq_ctrl_tb_top.sv
module pinbank_irq_ctrl_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  pins = '0;
    logic        reg_wr = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic [31:0] trig_sh = 32'hFFFF_FFFF;

    always #5 clk = ~clk;

    pinbank_irq_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .pin_i      (pins),
        .reg_wr_i   (reg_wr),
        .reg_addr_i (reg_addr),
        .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata),
        .irq_o      (irq)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic set_trig(input int pin, input logic [3:0] code);
        trig_sh[4*pin +: 4] = code;
        wr(3'd0, trig_sh);
    endtask

    task automatic pulse(input int pin, input int len);
        @(negedge clk);
        pins[pin] = 1'b1;
        idle(len);
        pins[pin] = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(3'd0, v); chk(v == 32'hFFFF_FFFF, "R1 trigger reset", v, 32'hFFFF_FFFF);
        rd(3'd3, v); chk(v == 32'hFF, "R10 mask reset", v, 32'hFF);
        rd(3'd4, v); chk(v == 0, "R11 pending reset", v, 0);
        rd(3'd1, v); chk(v == 0, "R11 filter lo reset", v, 0);
        rd(3'd2, v); chk(v == 0, "R11 filter hi reset", v, 0);
        chk(irq == 1'b0, "R11 irq reset", {31'b0, irq}, 0);
    endtask

    task automatic t_rising();
        logic [31:0] v;
        wr(3'd3, 32'hFE);
        set_trig(0, 4'd3);
        pins[0] = 1'b1; idle(6);
        rd(3'd4, v); chk(v[0] == 1'b1, "R2 rising sets pending", v, 32'h1);
        chk(irq == 1'b1, "R10 unmasked irq", {31'b0, irq}, 1);
        wr(3'd4, 32'h1); idle(6);
        rd(3'd4, v); chk(v[0] == 1'b0, "R7 edge fires once / R8 cleared", v, 0);
        pins[0] = 1'b0; idle(6);
        rd(3'd4, v); chk(v[0] == 1'b0, "R2 rising ignores fall", v, 0);
    endtask

    task automatic t_fall_both();
        logic [31:0] v;
        set_trig(1, 4'd2);
        pins[1] = 1'b1; idle(6);
        rd(3'd4, v); chk(v[1] == 1'b0, "R2 falling ignores rise", v, 0);
        pins[1] = 1'b0; idle(6);
        rd(3'd4, v); chk(v[1] == 1'b1, "R2 falling sets pending", v, 32'h2);
        wr(3'd4, 32'h2);
        set_trig(2, 4'd4);
        pins[2] = 1'b1; idle(6);
        rd(3'd4, v); chk(v[2] == 1'b1, "R2 both-edge on rise", v, 32'h4);
        wr(3'd4, 32'h0); idle(1);
        rd(3'd4, v); chk(v[2] == 1'b1, "R8 write 0 keeps pending", v, 32'h4);
        wr(3'd4, 32'h4);
        pins[2] = 1'b0; idle(6);
        rd(3'd4, v); chk(v[2] == 1'b1, "R2 both-edge on fall", v, 32'h4);
        wr(3'd4, 32'h4);
    endtask

    task automatic t_level();
        logic [31:0] v;
        set_trig(3, 4'd1);
        pins[3] = 1'b1; idle(6);
        rd(3'd4, v); chk(v[3] == 1'b1, "R2 level high", v, 32'h8);
        wr(3'd4, 32'h8);
        rd(3'd4, v); chk(v[3] == 1'b1, "R9 event beats clear / R7 level repeats", v, 32'h8);
        pins[3] = 1'b0; idle(6);
        wr(3'd4, 32'h8); idle(2);
        rd(3'd4, v); chk(v[3] == 1'b0, "R8 clear after level gone", v, 0);
        set_trig(3, 4'hF);
        set_trig(4, 4'd0); idle(6);
        rd(3'd4, v); chk(v[4] == 1'b1, "R2 level low", v, 32'h10);
        set_trig(4, 4'hF);
        wr(3'd4, 32'h10); idle(2);
        rd(3'd4, v); chk(v[4] == 1'b0, "R8 clear level low", v, 0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        set_trig(5, 4'd9);
        for (int k = 0; k < 4; k++) begin
            pins[5] = ~pins[5]; idle(5);
        end
        set_trig(5, 4'd15);
        pins[5] = 1'b1; idle(5); pins[5] = 1'b0; idle(6);
        rd(3'd4, v); chk(v[5] == 1'b0, "R3 codes 9 and 15 disabled", v, 0);
    endtask

    task automatic t_mask();
        logic [31:0] v;
        wr(3'd3, 32'hFF);
        pins[0] = 1'b1; idle(6);
        rd(3'd4, v); chk(v[0] == 1'b1, "R10 masked pin still pends", v, 32'h1);
        chk(irq == 1'b0, "R10 masked irq low", {31'b0, irq}, 0);
        wr(3'd3, 32'hFE); idle(1);
        chk(irq == 1'b1, "R10 unmask raises irq", {31'b0, irq}, 1);
        wr(3'd4, 32'h1); idle(1);
        chk(irq == 1'b0, "R10 irq drops on clear", {31'b0, irq}, 0);
        pins[0] = 1'b0; idle(4);
    endtask

    task automatic t_filter();
        logic [31:0] v;
        set_trig(6, 4'd3);
        wr(3'd2, 32'h00C5_0000);
        rd(3'd2, v); chk(v == 32'h00C5_0000, "R4 filter byte readback", v, 32'h00C5_0000);
        pulse(6, 4); idle(12);
        rd(3'd4, v); chk(v[6] == 1'b0, "R6 pulse shorter than width dropped", v, 0);
        pins[6] = 1'b1; idle(3); pins[6] = 1'b0; idle(1);
        pins[6] = 1'b1; idle(3); pins[6] = 1'b0; idle(12);
        rd(3'd4, v); chk(v[6] == 1'b0, "R6 glitch restarts count", v, 0);
        pulse(6, 5); idle(12);
        rd(3'd4, v); chk(v[6] == 1'b1, "R6 pulse equal to width passes", v, 32'h40);
        wr(3'd4, 32'h40);
        set_trig(7, 4'd3);
        wr(3'd2, 32'h85C5_0000);
        pulse(7, 1); idle(6);
        rd(3'd4, v); chk(v[7] == 1'b1, "R5 analog mode passes 1-cycle pulse", v, 32'h80);
        wr(3'd4, 32'h80);
        wr(3'd2, 32'hC0C5_0000);
        pulse(7, 1); idle(6);
        rd(3'd4, v); chk(v[7] == 1'b1, "R5 width 0 passes 1-cycle pulse", v, 32'h80);
        wr(3'd4, 32'h80);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        t_reset();
        t_rising();
        t_fall_both();
        t_level();
        t_disabled();
        t_mask();
        t_filter();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule